// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block guards a battery-backed static memory while its main supply rises and falls. Analog comparators outside the block supply three digital flags. Two flags say the supply is below the fail-detect threshold, one flag for each supply-tolerance variant. The third flag says the supply is below the level at which the backup cell takes over. The block synchronizes and deglitches these flags. It then sequences five states: normal, draining, protected, on backup and recovering. From that state it gates the host's chip-enable toward the array, controls the data-output drivers, selects the backup source and reports write protection.

When the supply fails, an access that is already running may finish. Protection is forced once a bounded number of cycles has passed. When the supply comes back, protection is held for a long recovery window before host strobes reach the array again. The backup source stays isolated until the supply has been seen good once. A sticky arming flag records that event. Only a dedicated factory-reset input clears it. All timings are parameters counted in clock ticks.

Top module: `pwrfail_guard`

## Requirements
- R1: While `rst_n` is low, `wp_o`=1, `arr_ce_n_o`=1, `dq_oe_o`=0 and `bkp_sel_o`=0, whatever the strobes do. Reset leaves the block in the protected state, treating the supply as failed.
- R2: In the normal state `wp_o`=0 and `arr_ce_n_o` equals `ce_n_i`. `dq_oe_o` is 1 exactly when `ce_n_i`=0, `we_n_i`=1 and `oe_n_i`=0 (all strobes active low).
- R3: A change of a comparator flag reaches the state register FILT_LEN+2 clock edges after the first edge that samples it. If no access is busy, a fail flag moves the normal state straight to the protected state. There `arr_ce_n_o`=1 and `dq_oe_o`=0 whatever the strobes do.
- R4: A flag pulse that lasts fewer than FILT_LEN sampling edges has no effect on the state.
- R5: If `cyc_busy_i`=1 when the fail flag takes effect, the block enters a draining state. There `wp_o`=1 and `ce_n_i` still passes to `arr_ce_n_o`.
- R6: The draining state lasts at most WPT_TICKS clock edges, after which protection is forced.
- R7: When `cyc_busy_i` falls during draining, protection begins at the next clock edge.
- R8: While the switch-over flag is set in the protected state, the block is in the backup state. There `bkp_sel_o`=1 if the block is armed. When the flag clears, the block returns to the protected state and `bkp_sel_o`=0.
- R9: The block becomes armed the first time the filtered fail flag is low, and it stays armed across `rst_n`. `factory_rst_n`=0 disarms it at once, and an unarmed block keeps `bkp_sel_o`=0 in the backup state.
- R10: Once the fail flag clears, protection holds for exactly REC_TICKS clock edges of recovery before the normal state returns.
- R11: A fail flag during recovery returns the block to the protected state, and a later clear restarts the full recovery window.
- R12: Parameter WIDE_TOL selects which fail flag counts: 0 selects `fail_std_i` and 1 selects `fail_wide_i`. The other flag has no effect.
- R13: `wp_o` is 1 in every state except the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the sequencer and filters |
| factory_rst_n | input | 1 | Active-low clear of the sticky arming flag |
| fail_std_i | input | 1 | Supply below the fail threshold, narrow-tolerance comparator |
| fail_wide_i | input | 1 | Supply below the fail threshold, wide-tolerance comparator |
| sw_lo_i | input | 1 | Supply below the backup switch-over level |
| cyc_busy_i | input | 1 | A memory cycle is in progress |
| ce_n_i | input | 1 | Host chip enable, active low |
| we_n_i | input | 1 | Host write enable, active low |
| oe_n_i | input | 1 | Host output enable, active low |
| arr_ce_n_o | output | 1 | Gated chip enable toward the array, active low |
| dq_oe_o | output | 1 | Data output driver enable |
| bkp_sel_o | output | 1 | Select the backup supply source |
| wp_o | output | 1 | Write protection active |

## Verification
A wrong state shows at the ports within one clock edge. A missed transition to protection leaves `arr_ce_n_o` following the host strobes when it should be high. A spurious exit from recovery drops `wp_o` early. The bench therefore counts edges from each flag change to the port event and compares each count with its exact expected value. A timer that is off by one, a wrong filter length or a lost arming bit each changes a count or a level on `bkp_sel_o`. In the forced states, random strobes confirm that nothing leaks through.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_PROT   = 3'd2,
        ST_BACKUP = 3'd3,
        ST_RECOV  = 3'd4
    } pfg_state_e;
endpackage

// File: rtl/pfg_deglitch.sv
module pfg_deglitch #(
    parameter int   LEN     = 3,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          flt;
    } dg_t;

    dg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], raw_i};
        if (r_q.sync[1] == r_q.flt) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(LEN - 1)) begin
            r_d.flt = r_q.sync[1];
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sync <= {2{RST_VAL}};
            r_q.cnt  <= '0;
            r_q.flt  <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign flt_o = r_q.flt;
endmodule

// File: rtl/pfg_access_gate.sv
module pfg_access_gate (
    input  logic pass_i,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic arr_ce_n_o,
    output logic dq_oe_o
);
    always_comb begin
        arr_ce_n_o = pass_i ? ce_n_i : 1'b1;
        dq_oe_o    = pass_i & ~ce_n_i & we_n_i & ~oe_n_i;
    end
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard #(
    parameter int FILT_LEN  = 3,
    parameter int WPT_TICKS = 12,
    parameter int REC_TICKS = 64,
    parameter bit WIDE_TOL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic factory_rst_n,
    input  logic fail_std_i,
    input  logic fail_wide_i,
    input  logic sw_lo_i,
    input  logic cyc_busy_i,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic oe_n_i,
    output logic arr_ce_n_o,
    output logic dq_oe_o,
    output logic bkp_sel_o,
    output logic wp_o
);
    import pfg_pkg::*;

    localparam int       NFLAG    = 3;
    localparam int       TMAX     = (REC_TICKS > WPT_TICKS) ? REC_TICKS : WPT_TICKS;
    localparam int       TW       = $clog2(TMAX + 1);
    localparam logic [NFLAG-1:0] FLAG_RST = 3'b011;

    typedef struct packed {
        pfg_state_e    state;
        logic [TW-1:0] tmr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic armed_d, armed_q;

    logic [NFLAG-1:0] raw_flags, flt_flags;
    logic             fail_f, swlo_f, pass;

    assign raw_flags = {sw_lo_i, fail_wide_i, fail_std_i};

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        pfg_deglitch #(.LEN(FILT_LEN), .RST_VAL(FLAG_RST[gi])) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_flags[gi]),
            .flt_o (flt_flags[gi])
        );
    end

    if (WIDE_TOL) begin : g_wide
        assign fail_f = flt_flags[1];
    end else begin : g_std
        assign fail_f = flt_flags[0];
    end
    assign swlo_f = flt_flags[2];

    always_comb begin
        ctl_d   = ctl_q;
        armed_d = armed_q | ~fail_f;
        unique case (ctl_q.state)
            ST_NORMAL: begin
                if (fail_f) begin
                    if (cyc_busy_i) begin
                        ctl_d.state = ST_DRAIN;
                        ctl_d.tmr   = TW'(WPT_TICKS - 1);
                    end else begin
                        ctl_d.state = ST_PROT;
                    end
                end
            end
            ST_DRAIN: begin
                if (!cyc_busy_i || ctl_q.tmr == '0) begin
                    ctl_d.state = ST_PROT;
                end else begin
                    ctl_d.tmr = ctl_q.tmr - 1'b1;
                end
            end
            ST_PROT: begin
                if (swlo_f) begin
                    ctl_d.state = ST_BACKUP;
                end else if (!fail_f) begin
                    ctl_d.state = ST_RECOV;
                    ctl_d.tmr   = TW'(REC_TICKS - 1);
                end
            end
            ST_BACKUP: begin
                if (!swlo_f) ctl_d.state = ST_PROT;
            end
            ST_RECOV: begin
                if (fail_f) begin
                    ctl_d.state = ST_PROT;
                end else if (ctl_q.tmr == '0) begin
                    ctl_d.state = ST_NORMAL;
                end else begin
                    ctl_d.tmr = ctl_q.tmr - 1'b1;
                end
            end
            default: ctl_d.state = ST_PROT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_PROT;
            ctl_q.tmr   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk or negedge factory_rst_n) begin
        if (!factory_rst_n) armed_q <= 1'b0;
        else                armed_q <= armed_d;
    end

    assign pass = rst_n && (ctl_q.state == ST_NORMAL || ctl_q.state == ST_DRAIN);

    pfg_access_gate u_gate (
        .pass_i     (pass),
        .ce_n_i     (ce_n_i),
        .we_n_i     (we_n_i),
        .oe_n_i     (oe_n_i),
        .arr_ce_n_o (arr_ce_n_o),
        .dq_oe_o    (dq_oe_o)
    );

    assign bkp_sel_o = rst_n && armed_q && (ctl_q.state == ST_BACKUP);
    assign wp_o      = !rst_n || (ctl_q.state != ST_NORMAL);
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
    parameter int WPT_TICKS = 12
) (
    input logic               clk,
    input logic               rst_n,
    input pfg_pkg::pfg_state_e state,
    input logic               armed,
    input logic               ce_n,
    input logic               arr_ce_n,
    input logic               dq_oe,
    input logic               bkp_sel,
    input logic               wp
);
    import pfg_pkg::*;

    logic [15:0] drain_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                drain_cnt <= '0;
        else if (state == ST_DRAIN) drain_cnt <= drain_cnt + 1'b1;
        else                       drain_cnt <= '0;
    end

    a_r2_ce_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !wp |-> (arr_ce_n == ce_n));

    a_r3_quiet_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROT || state == ST_BACKUP || state == ST_RECOV) |-> (arr_ce_n && !dq_oe));

    a_r6_drain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (drain_cnt < 16'(WPT_TICKS)));

    a_r9_backup_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        bkp_sel |-> (armed && state == ST_BACKUP));

    a_r10_normal_after_recov: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_NORMAL) |-> ($past(state) == ST_RECOV));

    a_r13_wp_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NORMAL) |-> wp);
endmodule

bind pwrfail_guard pfg_checker #(.WPT_TICKS(WPT_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (ctl_q.state),
    .armed    (armed_q),
    .ce_n     (ce_n_i),
    .arr_ce_n (arr_ce_n_o),
    .dq_oe    (dq_oe_o),
    .bkp_sel  (bkp_sel_o),
    .wp       (wp_o)
);

// File: tb/tb_pwrfail_guard.sv
module tb_pwrfail_guard;
    localparam int F   = 3;
    localparam int WPT = 12;
    localparam int REC = 64;
    localparam int LAT = F + 3;

    logic clk = 1'b0;
    logic rst_n, factory_rst_n, fail_std, fail_wide, sw_lo, busy, ce_n, we_n, oe_n;
    logic arr_ce_n, dq_oe, bkp_sel, wp;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwrfail_guard #(.FILT_LEN(F), .WPT_TICKS(WPT), .REC_TICKS(REC), .WIDE_TOL(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .factory_rst_n(factory_rst_n),
        .fail_std_i(fail_std), .fail_wide_i(fail_wide), .sw_lo_i(sw_lo),
        .cyc_busy_i(busy), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .arr_ce_n_o(arr_ce_n), .dq_oe_o(dq_oe), .bkp_sel_o(bkp_sel), .wp_o(wp)
    );

    function automatic logic exp_oe(input logic c, input logic w, input logic o);
        return ~c & w & ~o;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0:       return wp;
            1:       return arr_ce_n;
            default: return bkp_sel;
        endcase
    endfunction

    task automatic meas(input string tag, input int sel, input logic val, input int exp);
        int n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (pick(sel) != val && n < 2000);
        chk(n == exp, tag, n, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_strobes(input string tag, input bit locked, input int iters);
        for (int i = 0; i < iters; i++) begin
            @(negedge clk);
            ce_n = 1'($urandom); we_n = 1'($urandom); oe_n = 1'($urandom);
            #2;
            if (locked) begin
                chk(arr_ce_n == 1'b1 && dq_oe == 1'b0, tag, {arr_ce_n, dq_oe}, 2);
            end else begin
                chk(arr_ce_n == ce_n && dq_oe == exp_oe(ce_n, we_n, oe_n), tag,
                    {arr_ce_n, dq_oe}, {ce_n, exp_oe(ce_n, we_n, oe_n)});
            end
        end
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic recover;
        @(negedge clk);
        fail_std = 1'b0;
        meas("R10 recovery length", 0, 1'b0, LAT + REC);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        rst_n = 0; factory_rst_n = 0; fail_std = 1; fail_wide = 1; sw_lo = 0;
        busy = 0; ce_n = 0; we_n = 1; oe_n = 0;
        idle(4);
        chk(wp == 1 && arr_ce_n == 1 && dq_oe == 0 && bkp_sel == 0, "R1 reset outputs",
            {wp, arr_ce_n, dq_oe, bkp_sel}, 4'b1100);
        ce_n = 1;
        @(negedge clk); rst_n = 1; factory_rst_n = 1;
        idle(3);
        chk(wp == 1, "R1 protected after reset", wp, 1);

        // first power good: recovery window, arming
        @(negedge clk); fail_std = 0; fail_wide = 0;
        meas("R10 first recovery", 0, 1'b0, LAT + REC);

        rand_strobes("R2 normal passthrough", 1'b0, 120);

        // glitch shorter than the filter
        @(negedge clk); fail_std = 1;
        idle(F - 1);
        fail_std = 0;
        idle(12);
        chk(wp == 0, "R4 short pulse ignored", wp, 0);

        // unselected variant flag
        @(negedge clk); fail_wide = 1;
        idle(20);
        chk(wp == 0, "R12 wide flag ignored", wp, 0);
        rand_strobes("R12 still normal", 1'b0, 8);
        fail_wide = 0;

        // fail with no access
        @(negedge clk); fail_std = 1;
        meas("R3 fail latency", 0, 1'b1, LAT);
        rand_strobes("R3 strobes blocked", 1'b1, 40);
        chk(wp == 1, "R13 wp in protected", wp, 1);

        // backup switch
        @(negedge clk); sw_lo = 1;
        meas("R8 backup select", 2, 1'b1, LAT);
        chk(wp == 1, "R13 wp in backup", wp, 1);
        @(negedge clk); sw_lo = 0;
        meas("R8 backup release", 2, 1'b0, LAT);

        // dip during recovery
        @(negedge clk); fail_std = 0;
        idle(30);
        chk(wp == 1, "R10 still protected mid-recovery", wp, 1);
        fail_std = 1;
        idle(F + 6);
        fail_std = 0;
        meas("R11 restarted recovery", 0, 1'b0, LAT + REC);

        // access drains until timeout
        @(negedge clk); ce_n = 0; busy = 1; fail_std = 1;
        meas("R5 drain entry", 0, 1'b1, LAT);
        chk(arr_ce_n == 0, "R5 ce passes in drain", arr_ce_n, 0);
        meas("R6 forced protect after timeout", 1, 1'b1, WPT);
        busy = 0; ce_n = 1;
        recover();

        // access ends early
        @(negedge clk); ce_n = 0; busy = 1; fail_std = 1;
        meas("R5 drain entry 2", 0, 1'b1, LAT);
        idle(3);
        chk(arr_ce_n == 0, "R5 ce still passes", arr_ce_n, 0);
        busy = 0;
        meas("R7 protect after busy ends", 1, 1'b1, 1);
        ce_n = 1;
        recover();

        // factory isolation
        @(negedge clk); fail_std = 1; sw_lo = 1;
        idle(LAT + 4);
        chk(bkp_sel == 1, "R9 armed backup", bkp_sel, 1);
        @(negedge clk); factory_rst_n = 0;
        #2;
        chk(bkp_sel == 0, "R9 factory clear isolates", bkp_sel, 0);
        @(negedge clk); factory_rst_n = 1;
        idle(10);
        chk(bkp_sel == 0, "R9 stays isolated", bkp_sel, 0);
        sw_lo = 0;
        idle(LAT + 2);
        recover();
        @(negedge clk); fail_std = 1; sw_lo = 1;
        idle(2 * LAT + 4);
        chk(bkp_sel == 1, "R9 re-armed after power good", bkp_sel, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule